// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits behind the serial front end of a small non-volatile byte memory and handles array writes. A write sequence opens with a start pulse carrying a 7-bit start address. The block then counts the data bits that the front end announces and takes each completed byte into a 16-byte page latch. The latch offset wraps inside the page, so a long burst loops back to the first byte of the same page and overwrites what it latched there. The block never advances into the next page.

When the front end reports that chip select has risen, the block decides whether the sequence ended exactly on a byte boundary with at least one byte received. If it did, the block enters a self-timed program cycle of fixed length (a parameter in clock cycles). During that cycle a busy flag is raised and every new access is refused. At the end of the cycle only the lanes that received data are written into the 128-byte array. If the sequence did not end on a byte boundary, the whole write is dropped. A read port gives the front end access to the array whenever no program cycle is running.

The control is a four-state machine:
- IDLE to COLLECT on an accepted start.
- COLLECT to PROGRAM on a chip-select rise that lands on a byte boundary after at least one byte.
- COLLECT to IDLE on any other chip-select rise (abort).
- PROGRAM to FINISH when the timer expires.
- FINISH to IDLE after one cycle. This is the cycle in which the array is written and the write-enable clear pulse is issued.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset `busy_o`, `rd_valid_o` and `wel_clr_o` are 0 and every array byte reads as 0x00.
- R2: The first data byte of a sequence goes to the start address. Each later byte goes to the next offset. The low 4 address bits wrap from 0xF to 0x0 while the upper 3 bits stay the same (start 0x7E with 4 bytes writes 0x7E, 0x7F, 0x70, 0x71).
- R3: When more than 16 bytes arrive in one sequence, the later bytes overwrite the bytes latched earlier at the same offsets, and the array receives the last value for each offset.
- R4: A write commits only if `cs_rise_i` arrives while the count of `bit_i` pulses since the start is a multiple of 8 and at least one byte has been taken. On any other `cs_rise_i` in COLLECT, no program cycle starts and the array is left unchanged.
- R5: A committed write changes only the offsets that received a byte in that sequence. All other bytes of the page keep their old values.
- R6: `busy_o` rises in the cycle after the committing `cs_rise_i` and stays high for exactly WR_CYCLES+1 cycles. The array contents are updated by the time `busy_o` falls.
- R7: `wel_clr_o` is a single-cycle pulse issued in the last cycle in which `busy_o` is high.
- R8: A read request made while `busy_o` is low returns `rd_valid_o`=1 and the byte at `rd_addr_i` one cycle later. A read request made while `busy_o` is high gets no `rd_valid_o`.
- R9: While `busy_o` is high, `start_i`, `bit_i`, `byte_valid_i` and `cs_rise_i` are ignored. The running cycle completes, and no second cycle follows it.
- R10: Outside a sequence (in IDLE), `bit_i`, `byte_valid_i` and `cs_rise_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: a write sequence begins, address valid |
| start_addr_i | input | 7 | Start address of the write |
| bit_i | input | 1 | Pulse: one data bit received |
| byte_valid_i | input | 1 | Pulse with the 8th bit: a data byte is complete |
| byte_data_i | input | 8 | Completed data byte |
| cs_rise_i | input | 1 | Pulse: chip select has risen |
| rd_en_i | input | 1 | Array read request |
| rd_addr_i | input | 7 | Array read address |
| rd_data_o | output | 8 | Read data, one cycle after the request |
| rd_valid_o | output | 1 | Read data valid |
| busy_o | output | 1 | Write cycle in progress |
| wel_clr_o | output | 1 | Pulse: clear the write enable latch |

## Verification
The hardest case to reach is a chip-select rise that comes after whole bytes plus a few stray bits. The array must then stay untouched even though the latch holds valid lanes. The bench reaches this case by following complete bytes with a chosen number of extra bit pulses (3 and 7), and then reading back the entire page. A second hard case is a burst that wraps and overwrites itself. It is produced by an 18-byte sequence and by a start near the top of the last page. The refused-access window is tested by sending a start, bits, a byte, a chip-select rise and a read while busy is high. The bench then watches for a second cycle that must not come.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2,
        ST_FINISH  = 2'd3
    } pwb_state_t;
endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8,
    localparam int LANES = 1 << PAGE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic [PAGE_W-1:0]             load_off,
    input  logic                          wr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [LANES-1:0][DATA_W-1:0]  lane_data,
    output logic [LANES-1:0]              lane_valid
);
    logic [PAGE_W-1:0] off_q;

    // offset counter wraps naturally inside the page
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q      <= '0;
            lane_valid <= '0;
            lane_data  <= '0;
        end else if (clear) begin
            off_q      <= load_off;
            lane_valid <= '0;
        end else if (wr) begin
            lane_data[off_q]  <= wdata;
            lane_valid[off_q] <= 1'b1;
            off_q             <= off_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8,
    localparam int LANES = 1 << PAGE_W,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int SEL_W = ADDR_W - PAGE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [SEL_W-1:0]              page_sel,
    input  logic [LANES-1:0][DATA_W-1:0]  lane_data,
    input  logic [LANES-1:0]              lane_valid,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          rd_valid
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [LANES-1:0]  lane_we;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = commit & lane_valid[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_we[i]) mem[{page_sel, PAGE_W'(i)}] <= lane_data[i];
            end
            rd_valid <= rd_en;
            if (rd_en) rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
    parameter int CYCLES = 50000,
    localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl #(
    parameter int ADDR_W    = 7,
    parameter int PAGE_W    = 4,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              bit_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              cs_rise_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              busy_o,
    output logic              wel_clr_o
);
    import pwb_pkg::*;

    localparam int LANES = 1 << PAGE_W;
    localparam int SEL_W = ADDR_W - PAGE_W;
    localparam int BIT_W = $clog2(DATA_W);

    pwb_state_t state_q, state_d;

    logic [SEL_W-1:0]             page_q;
    logic [BIT_W-1:0]             bitcnt_q;
    logic [LANES-1:0][DATA_W-1:0] lane_data;
    logic [LANES-1:0]             lane_valid;
    logic                         start_acc, take_byte, commit, expired, on_boundary;

    assign start_acc   = start_i && (state_q == ST_IDLE);
    assign take_byte   = byte_valid_i && (state_q == ST_COLLECT);
    assign on_boundary = (bitcnt_q == '0) && (|lane_valid);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_acc) state_d = ST_COLLECT;
            ST_COLLECT: if (cs_rise_i) state_d = on_boundary ? ST_PROGRAM : ST_IDLE;
            ST_PROGRAM: if (expired)   state_d = ST_FINISH;
            ST_FINISH:                 state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs from state
    always_comb begin
        busy_o    = 1'b0;
        wel_clr_o = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_COLLECT: ;
            ST_PROGRAM: busy_o = 1'b1;
            ST_FINISH: begin
                busy_o    = 1'b1;
                wel_clr_o = 1'b1;
                commit    = 1'b1;
            end
            default: ;
        endcase
    end

    // page base and bit position within the current byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q   <= '0;
            bitcnt_q <= '0;
        end else if (start_acc) begin
            page_q   <= start_addr_i[ADDR_W-1:PAGE_W];
            bitcnt_q <= '0;
        end else if (bit_i && state_q == ST_COLLECT) begin
            bitcnt_q <= bitcnt_q + 1'b1;
        end
    end

    pwb_page_latch #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start_acc),
        .load_off   (start_addr_i[PAGE_W-1:0]),
        .wr         (take_byte),
        .wdata      (byte_data_i),
        .lane_data  (lane_data),
        .lane_valid (lane_valid)
    );

    pwb_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_PROGRAM),
        .expired (expired)
    );

    pwb_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .page_sel   (page_q),
        .lane_data  (lane_data),
        .lane_valid (lane_valid),
        .rd_en      (rd_en_i && !busy_o),
        .rd_addr    (rd_addr_i),
        .rd_data    (rd_data_o),
        .rd_valid   (rd_valid_o)
    );
endmodule

// File: rtl/pwb_ctrl_chk.sv
module pwb_ctrl_chk #(
    parameter int WR_CYCLES = 50000,
    localparam int LEN_W = $clog2(WR_CYCLES + 2) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic cs_rise_i,
    input logic rd_en_i,
    input logic rd_valid_o,
    input logic busy_o,
    input logic wel_clr_o
);
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      len_q <= '0;
        else if (busy_o) len_q <= len_q + 1'b1;
        else             len_q <= '0;
    end

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (len_q == LEN_W'(WR_CYCLES + 1)));

    // R6
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cs_rise_i));

    // R7
    wel_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_o |-> busy_o);

    // R7
    wel_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_o |=> !busy_o);

    // R8
    rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && busy_o) |=> !rd_valid_o);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !wel_clr_o) |=> busy_o);
endmodule

bind pwb_ctrl pwb_ctrl_chk #(.WR_CYCLES(WR_CYCLES)) u_pwb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_rise_i  (cs_rise_i),
    .rd_en_i    (rd_en_i),
    .rd_valid_o (rd_valid_o),
    .busy_o     (busy_o),
    .wel_clr_o  (wel_clr_o)
);

// File: tb/pwb_ctrl_test.sv
module pwb_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WR = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [6:0] start_addr_i = '0;
    logic       bit_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_data_i = '0;
    logic       cs_rise_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [6:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       rd_valid_o, busy_o, wel_clr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [128];

    // {addr[6:0], nbytes[4:0], extra_bits[2:0], first_data[7:0]}
    localparam logic [22:0] VECS [8] = '{
        {7'h05, 5'd1,  3'd0, 8'h11},
        {7'h7E, 5'd4,  3'd0, 8'h20},
        {7'h30, 5'd18, 3'd0, 8'h40},
        {7'h45, 5'd3,  3'd3, 8'h60},
        {7'h50, 5'd0,  3'd0, 8'h70},
        {7'h22, 5'd16, 3'd0, 8'h80},
        {7'h00, 5'd2,  3'd7, 8'h90},
        {7'h08, 5'd1,  3'd0, 8'hFF}
    };

    pwb_ctrl #(.WR_CYCLES(WR)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .bit_i(bit_i), .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .cs_rise_i(cs_rise_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .busy_o(busy_o),
        .wel_clr_o(wel_clr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d, output logic v);
        @(negedge clk); rd_en_i = 1'b1; rd_addr_i = a;
        @(negedge clk); rd_en_i = 1'b0;
        d = rd_data_o; v = rd_valid_o;
    endtask

    task automatic check_page(input logic [2:0] pg, input string tag);
        logic [7:0] d; logic v;
        for (int k = 0; k < 16; k++) begin
            rd({pg, 4'(k)}, d, v);
            chk(v === 1'b1, "R8 rd_valid", int'(v), 1);
            chk(d === model[{pg, 4'(k)}], tag, int'(d), int'(model[{pg, 4'(k)}]));
        end
    endtask

    task automatic pulse_bits(input int n);
        for (int b = 0; b < n; b++) begin
            @(negedge clk); bit_i = 1'b1;
            @(negedge clk); bit_i = 1'b0;
        end
    endtask

    task automatic send_seq(input logic [6:0] a, input int n, input int p, input logic [7:0] d0);
        @(negedge clk); start_i = 1'b1; start_addr_i = a;
        @(negedge clk); start_i = 1'b0;
        for (int k = 0; k < n; k++) begin
            pulse_bits(7);
            @(negedge clk); bit_i = 1'b1; byte_valid_i = 1'b1; byte_data_i = d0 + 8'(k);
            @(negedge clk); bit_i = 1'b0; byte_valid_i = 1'b0;
        end
        pulse_bits(p);
        @(negedge clk); cs_rise_i = 1'b1;
        @(negedge clk); cs_rise_i = 1'b0;
    endtask

    // called at the negedge right after cs_rise was dropped
    task automatic watch_cycle(input bit expect_busy, input string tag);
        int len = 0; int wel_n = 0; int wel_at = 0;
        chk(busy_o === expect_busy, tag, int'(busy_o), int'(expect_busy));
        if (expect_busy) begin
            while (busy_o === 1'b1 && len < 1000) begin
                len++;
                if (wel_clr_o === 1'b1) begin wel_n++; wel_at = len; end
                @(negedge clk);
            end
            chk(len == WR + 1, "R6 busy length", len, WR + 1);
            chk(wel_n == 1 && wel_at == WR + 1, "R7 wel_clr pulse", wel_at, WR + 1);
        end else begin
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (busy_o !== 1'b0) begin
                    chk(1'b0, tag, int'(busy_o), 0);
                    break;
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d; logic v;
        for (int a = 0; a < 128; a++) model[a] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy_o === 1'b0, "R1 busy", int'(busy_o), 0);
        chk(rd_valid_o === 1'b0, "R1 rd_valid", int'(rd_valid_o), 0);
        chk(wel_clr_o === 1'b0, "R1 wel_clr", int'(wel_clr_o), 0);
        rst_n = 1'b1;
        rd(7'h7F, d, v);
        chk(v === 1'b1 && d === 8'h00, "R1 array clear", int'(d), 0);

        // table of sequences
        for (int i = 0; i < 8; i++) begin
            logic [6:0] a; int n; int p; logic [7:0] d0; bit commit_e; string tag;
            logic [3:0] off;
            a = VECS[i][22:16]; n = int'(VECS[i][15:11]); p = int'(VECS[i][10:8]); d0 = VECS[i][7:0];
            commit_e = (p == 0) && (n > 0);
            if (!commit_e)                tag = "R4 discard";
            else if (n > 16)              tag = "R3 overwrite";
            else if (int'(a[3:0]) + n > 16) tag = "R2 wrap";
            else                          tag = "R5 untouched";
            if (commit_e) begin
                off = a[3:0];
                for (int k = 0; k < n; k++) begin
                    model[{a[6:4], off}] = d0 + 8'(k);
                    off = off + 4'd1;
                end
            end
            send_seq(a, n, p, d0);
            watch_cycle(commit_e, commit_e ? "R6 busy rise" : "R4 no cycle");
            check_page(a[6:4], tag);
        end

        // R9: inputs during busy are ignored
        model[7'h61] = 8'hA5;
        send_seq(7'h61, 1, 0, 8'hA5);
        chk(busy_o === 1'b1, "R9 busy", int'(busy_o), 1);
        @(negedge clk); start_i = 1'b1; start_addr_i = 7'h62; rd_en_i = 1'b1; rd_addr_i = 7'h05;
        @(negedge clk); start_i = 1'b0; rd_en_i = 1'b0;
        chk(rd_valid_o === 1'b0, "R8 read blocked", int'(rd_valid_o), 0);
        @(negedge clk); bit_i = 1'b1; byte_valid_i = 1'b1; byte_data_i = 8'h3C;
        @(negedge clk); bit_i = 1'b0; byte_valid_i = 1'b0; cs_rise_i = 1'b1;
        @(negedge clk); cs_rise_i = 1'b0;
        while (busy_o === 1'b1) @(negedge clk);
        watch_cycle(1'b0, "R9 no second cycle");
        check_page(3'd6, "R9 page");

        // R10: stray events in idle
        @(negedge clk); bit_i = 1'b1; byte_valid_i = 1'b1; byte_data_i = 8'hEE;
        @(negedge clk); bit_i = 1'b0; byte_valid_i = 1'b0; cs_rise_i = 1'b1;
        @(negedge clk); cs_rise_i = 1'b0;
        watch_cycle(1'b0, "R10 idle cs_rise");
        check_page(3'd6, "R10 page");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule